// File: doc/BRIEF.md
# Processor Reset and Interrupt Entry Sequencer

This block is the control sequencer of an 8-bit processor core that brings the architectural registers to a known state on reset and carries out the entry into a maskable interrupt. It drives a byte-wide memory bus with a 16-bit address and performs at most one bus access per clock cycle. The read data is taken in the same cycle that the address is presented.

On reset it sets fixed values in the accumulator, both index registers, the stack pointer and the status register. It then reads the start address, low byte first, from a fixed vector at the top of memory. On an accepted interrupt it pushes the program counter and the status byte into the stack page, which grows downward. It then loads the program counter from the interrupt vector and sets the interrupt-disable flag.

Between sequences the block raises `ready_o` and presents the register state to an execution core. Instruction decode, execution and the ALU are outside the block. While ready, the core can write back the program counter, stack pointer and status.

Top module: `cpu_entry_seq`

## Requirements
- R1: While `cpu_rst_i` is high, and in the cycle after it falls, A, X and Y read 0x00, the stack pointer reads 0xFF and the status reads 0x34. The status bit order from MSB to LSB is N, V, unused, B, D, I, Z, C, so I is bit 2, D is bit 3 and B is bit 4.
- R2: After `cpu_rst_i` falls, or after `rst_ni` is released, the block reads 0xFFFC and then 0xFFFD, one per cycle. The program counter becomes {byte at 0xFFFD, byte at 0xFFFC}, and `ready_o` rises in the following cycle.
- R3: While `cpu_rst_i` is high the block makes no bus access, `ready_o` stays low, and `irq_i` has no effect.
- R4: An interrupt is accepted only in a cycle where `ready_o` is high, `irq_i` is high, status bit 2 is clear and `core_we_i` is low. `ready_o` is low in the next cycle.
- R5: An accepted interrupt makes three writes to address 0x0100 plus the stack pointer, in this order: PC[15:8], then PC[7:0], then the status byte. Each write decrements the stack pointer modulo 256.
- R6: After the pushes the block reads 0xFFFE and then 0xFFFF. The program counter becomes {byte at 0xFFFF, byte at 0xFFFE}, status bit 2 is set and `ready_o` rises again.
- R7: The block never asserts read and write in the same cycle. Every write goes to the page 0x01xx, and every read goes to 0xFFFC to 0xFFFF.
- R8: When `ready_o` and `core_we_i` are high, the program counter, stack pointer and status load from `pc_d_i`, `sp_d_i` and `p_d_i`. When `ready_o` is low, `core_we_i` is ignored.
- R9: While status bit 2 is set, `irq_i` is ignored: `ready_o` stays high and no write occurs.
- R10: Raising `cpu_rst_i` in the middle of an interrupt sequence abandons it. No further stack write is made and the reset sequence of R1 and R2 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of all flops |
| cpu_rst_i | input | 1 | Processor reset pin, active high, sampled on the clock |
| irq_i | input | 1 | Maskable interrupt request, level |
| bus_addr_o | output | 16 | Memory address |
| bus_rdata_i | input | 8 | Read data, valid in the cycle of the read |
| bus_wdata_o | output | 8 | Write data |
| bus_re_o | output | 1 | Read strobe |
| bus_we_o | output | 1 | Write strobe |
| ready_o | output | 1 | Register state valid for the execution core |
| core_we_i | input | 1 | Write-back strobe from the execution core |
| pc_d_i | input | 16 | Program counter write-back value |
| sp_d_i | input | 8 | Stack pointer write-back value |
| p_d_i | input | 8 | Status write-back value |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| p_o | output | 8 | Status register |
| a_o | output | 8 | Accumulator |
| x_o | output | 8 | Index register X |
| y_o | output | 8 | Index register Y |

## Verification
The bench first drives a push sequence that starts at stack pointer 0x01, so the third write has to wrap to 0x01FF. A design that borrows into the page byte would write to 0x00FF, and one that saturates would write to 0x0100 twice. It raises the interrupt while the I flag is set and checks that nothing happens, which catches a design that ignores the mask. It asserts the processor reset halfway through a push and checks that no write leaks out and that the vector is fetched again from the top. A design that lets the FSM finish first, or that gives the interrupt priority over reset, would show extra writes or a wrong program counter. It also strobes a core write-back during the push and checks that the program counter still comes from the interrupt vector.

// File: rtl/ces_pkg.sv
package ces_pkg;
  typedef enum logic [3:0] {
    ST_HOLD,
    ST_RVLO,
    ST_RVHI,
    ST_RUN,
    ST_PSH_HI,
    ST_PSH_LO,
    ST_PSH_ST,
    ST_IVLO,
    ST_IVHI
  } seq_st_e;
endpackage

// File: rtl/ces_ctrl.sv
module ces_ctrl
  import ces_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cpu_rst_i,
  input  logic    irq_i,
  input  logic    i_flag_i,
  input  logic    core_we_i,
  output seq_st_e state_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (cpu_rst_i) begin
      st_d = ST_HOLD;
    end else begin
      unique case (st_q)
        ST_HOLD:   st_d = ST_RVLO;
        ST_RVLO:   st_d = ST_RVHI;
        ST_RVHI:   st_d = ST_RUN;
        ST_RUN:    if (irq_i && !i_flag_i && !core_we_i) st_d = ST_PSH_HI;
        ST_PSH_HI: st_d = ST_PSH_LO;
        ST_PSH_LO: st_d = ST_PSH_ST;
        ST_PSH_ST: st_d = ST_IVLO;
        ST_IVLO:   st_d = ST_IVHI;
        ST_IVHI:   st_d = ST_RUN;
        default:   st_d = ST_HOLD;
      endcase
    end
  end

  // leaving async reset goes straight to the vector fetch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RVLO;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/ces_regs.sv
module ces_regs
  import ces_pkg::*;
#(
  parameter int          DW     = 8,
  parameter int          AW     = 2 * DW,
  parameter logic [7:0]  P_INIT = 8'h34,
  parameter logic [7:0]  SP_INIT = 8'hFF,
  parameter int          I_BIT  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_rst_i,
  input  seq_st_e       state_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          core_we_i,
  input  logic [AW-1:0] pc_d_i,
  input  logic [DW-1:0] sp_d_i,
  input  logic [DW-1:0] p_d_i,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] p_o,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [AW-1:0] pc_q;
  logic [DW-1:0] sp_q, p_q, a_q, x_q, y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      sp_q <= SP_INIT[DW-1:0];
      p_q  <= P_INIT[DW-1:0];
      a_q  <= '0;
      x_q  <= '0;
      y_q  <= '0;
    end else if (cpu_rst_i) begin
      sp_q <= SP_INIT[DW-1:0];
      p_q  <= P_INIT[DW-1:0];
      a_q  <= '0;
      x_q  <= '0;
      y_q  <= '0;
    end else begin
      unique case (state_i)
        ST_RVLO, ST_IVLO: pc_q[DW-1:0] <= rdata_i;
        ST_RVHI:          pc_q[AW-1:DW] <= rdata_i;
        ST_IVHI: begin
          pc_q[AW-1:DW] <= rdata_i;
          p_q[I_BIT]    <= 1'b1;
        end
        ST_RUN: if (core_we_i) begin
          pc_q <= pc_d_i;
          sp_q <= sp_d_i;
          p_q  <= p_d_i;
        end
        ST_PSH_HI, ST_PSH_LO, ST_PSH_ST: sp_q <= sp_q - ONE;
        default: ;
      endcase
    end
  end

  assign pc_o = pc_q;
  assign sp_o = sp_q;
  assign p_o  = p_q;
  assign a_o  = a_q;
  assign x_o  = x_q;
  assign y_o  = y_q;
endmodule

// File: rtl/ces_bus.sv
module ces_bus
  import ces_pkg::*;
#(
  parameter int           DW       = 8,
  parameter int           AW       = 2 * DW,
  parameter logic [15:0]  RST_VEC  = 16'hFFFC,
  parameter logic [15:0]  IRQ_VEC  = 16'hFFFE,
  parameter logic [7:0]   STK_PAGE = 8'h01
) (
  input  seq_st_e       state_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] p_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          re_o,
  output logic          we_o
);
  localparam logic [AW-1:0] RV = RST_VEC[AW-1:0];
  localparam logic [AW-1:0] IV = IRQ_VEC[AW-1:0];
  localparam logic [AW-1:0] A1 = AW'(1);

  logic [AW-1:0] stk_addr;
  assign stk_addr = {STK_PAGE[AW-DW-1:0], sp_i};

  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    re_o    = 1'b0;
    we_o    = 1'b0;
    unique case (state_i)
      ST_RVLO: begin addr_o = RV;      re_o = 1'b1; end
      ST_RVHI: begin addr_o = RV + A1; re_o = 1'b1; end
      ST_IVLO: begin addr_o = IV;      re_o = 1'b1; end
      ST_IVHI: begin addr_o = IV + A1; re_o = 1'b1; end
      ST_PSH_HI: begin addr_o = stk_addr; wdata_o = pc_i[AW-1:DW]; we_o = 1'b1; end
      ST_PSH_LO: begin addr_o = stk_addr; wdata_o = pc_i[DW-1:0];  we_o = 1'b1; end
      ST_PSH_ST: begin addr_o = stk_addr; wdata_o = p_i;           we_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu_entry_seq.sv
module cpu_entry_seq
  import ces_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          AW       = 16,
  parameter logic [15:0] RST_VEC  = 16'hFFFC,
  parameter logic [15:0] IRQ_VEC  = 16'hFFFE,
  parameter logic [7:0]  STK_PAGE = 8'h01,
  parameter logic [7:0]  P_INIT   = 8'h34,
  parameter logic [7:0]  SP_INIT  = 8'hFF,
  parameter int          I_BIT    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_rst_i,
  input  logic          irq_i,
  output logic [AW-1:0] bus_addr_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_re_o,
  output logic          bus_we_o,
  output logic          ready_o,
  input  logic          core_we_i,
  input  logic [AW-1:0] pc_d_i,
  input  logic [DW-1:0] sp_d_i,
  input  logic [DW-1:0] p_d_i,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] p_o,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o
);
  seq_st_e state;

  ces_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cpu_rst_i (cpu_rst_i),
    .irq_i     (irq_i),
    .i_flag_i  (p_o[I_BIT]),
    .core_we_i (core_we_i),
    .state_o   (state)
  );

  ces_regs #(
    .DW(DW), .AW(AW), .P_INIT(P_INIT), .SP_INIT(SP_INIT), .I_BIT(I_BIT)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cpu_rst_i (cpu_rst_i),
    .state_i   (state),
    .rdata_i   (bus_rdata_i),
    .core_we_i (core_we_i),
    .pc_d_i    (pc_d_i),
    .sp_d_i    (sp_d_i),
    .p_d_i     (p_d_i),
    .pc_o      (pc_o),
    .sp_o      (sp_o),
    .p_o       (p_o),
    .a_o       (a_o),
    .x_o       (x_o),
    .y_o       (y_o)
  );

  ces_bus #(
    .DW(DW), .AW(AW), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC), .STK_PAGE(STK_PAGE)
  ) u_bus (
    .state_i (state),
    .pc_i    (pc_o),
    .sp_i    (sp_o),
    .p_i     (p_o),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o),
    .re_o    (bus_re_o),
    .we_o    (bus_we_o)
  );

  assign ready_o = (state == ST_RUN);
endmodule

// File: rtl/ces_chk.sv
module ces_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cpu_rst_i,
  input logic        core_we_i,
  input logic [15:0] bus_addr_o,
  input logic        bus_re_o,
  input logic        bus_we_o,
  input logic        ready_o,
  input logic [7:0]  sp_o,
  input logic [7:0]  p_o,
  input logic [7:0]  a_o,
  input logic [7:0]  x_o,
  input logic [7:0]  y_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  a_r7_single_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_re_o && bus_we_o));

  a_r7_write_in_stack_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> bus_addr_o[15:8] == 8'h01);

  a_r7_read_from_vectors: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_o |-> bus_addr_o[15:2] == 14'h3FFF);

  a_r3_quiet_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(cpu_rst_i)) |-> (!bus_re_o && !bus_we_o && !ready_o));

  a_r1_reset_values: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(cpu_rst_i)) |->
      (sp_o == 8'hFF && p_o == 8'h34 && a_o == 8'h00 && x_o == 8'h00 && y_o == 8'h00));

  a_r5_sp_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(bus_we_o) && !$past(cpu_rst_i)) |-> sp_o == $past(sp_o) - 8'd1);

  a_r9_masked_irq_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && p_o[2] && !cpu_rst_i && !core_we_i) |=> ready_o);
endmodule

bind cpu_entry_seq ces_chk u_ces_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_rst_i  (cpu_rst_i),
  .core_we_i  (core_we_i),
  .bus_addr_o (bus_addr_o),
  .bus_re_o   (bus_re_o),
  .bus_we_o   (bus_we_o),
  .ready_o    (ready_o),
  .sp_o       (sp_o),
  .p_o        (p_o),
  .a_o        (a_o),
  .x_o        (x_o),
  .y_o        (y_o)
);

// File: tb/tb_cpu_entry_seq.sv
module tb_cpu_entry_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_rst = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] addr;
  logic [7:0]  rdata, wdata;
  logic        re, we, ready;
  logic        core_we = 1'b0;
  logic [15:0] pc_d = '0;
  logic [7:0]  sp_d = '0, p_d = '0;
  logic [15:0] pc;
  logic [7:0]  sp, p, a, x, y;

  always #5 clk = ~clk;

  cpu_entry_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_rst_i(cpu_rst), .irq_i(irq),
    .bus_addr_o(addr), .bus_rdata_i(rdata), .bus_wdata_o(wdata),
    .bus_re_o(re), .bus_we_o(we), .ready_o(ready),
    .core_we_i(core_we), .pc_d_i(pc_d), .sp_d_i(sp_d), .p_d_i(p_d),
    .pc_o(pc), .sp_o(sp), .p_o(p), .a_o(a), .x_o(x), .y_o(y)
  );

  // memory image: vectors only
  logic [7:0] rv_lo = 8'h34, rv_hi = 8'h12, iv_lo = 8'h78, iv_hi = 8'h56;
  function automatic logic [7:0] mem(input logic [15:0] ad);
    case (ad)
      16'hFFFC: return rv_lo;
      16'hFFFD: return rv_hi;
      16'hFFFE: return iv_lo;
      16'hFFFF: return iv_hi;
      default:  return 8'hEE;
    endcase
  endfunction
  assign rdata = mem(addr);

  int total = 0;
  int bad = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: phase 0 hold, 1/2 reset vector, 3 run, 4..6 push, 7/8 irq vector
  int          m_ph;
  logic [15:0] m_pc;
  logic [7:0]  m_sp, m_p, m_a, m_x, m_y;
  logic [7:0]  exp_wr[$];
  logic [15:0] exp_wa[$];
  logic [7:0]  got_wr[$];
  logic [15:0] got_wa[$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 1; m_pc = 16'h0; m_sp = 8'hFF; m_p = 8'h34; m_a = 0; m_x = 0; m_y = 0;
    end else if (cpu_rst) begin
      m_ph = 0; m_sp = 8'hFF; m_p = 8'h34; m_a = 0; m_x = 0; m_y = 0;
    end else begin
      case (m_ph)
        0: m_ph = 1;
        1: begin m_pc = {m_pc[15:8], mem(16'hFFFC)}; m_ph = 2; end
        2: begin m_pc = {mem(16'hFFFD), m_pc[7:0]}; m_ph = 3; end
        3: if (core_we) begin m_pc = pc_d; m_sp = sp_d; m_p = p_d; end
           else if (irq && !m_p[2]) m_ph = 4;
        4: begin exp_wr.push_back(m_pc[15:8]); exp_wa.push_back({8'h01, m_sp}); m_sp--; m_ph = 5; end
        5: begin exp_wr.push_back(m_pc[7:0]);  exp_wa.push_back({8'h01, m_sp}); m_sp--; m_ph = 6; end
        6: begin exp_wr.push_back(m_p);        exp_wa.push_back({8'h01, m_sp}); m_sp--; m_ph = 7; end
        7: begin m_pc = {m_pc[15:8], mem(16'hFFFE)}; m_ph = 8; end
        default: begin m_pc = {mem(16'hFFFF), m_pc[7:0]}; m_p[2] = 1'b1; m_ph = 3; end
      endcase
    end
  end

  function automatic string req_of(input int ph);
    case (ph)
      0: return "R3";
      1, 2: return "R2";
      3: return "R8";
      4, 5, 6: return "R5";
      default: return "R6";
    endcase
  endfunction

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    string r;
    logic [15:0] e_addr;
    logic        e_re, e_we;
    r = req_of(m_ph);
    e_re = (m_ph == 1 || m_ph == 2 || m_ph == 7 || m_ph == 8);
    e_we = (m_ph >= 4 && m_ph <= 6);
    case (m_ph)
      1: e_addr = 16'hFFFC;
      2: e_addr = 16'hFFFD;
      7: e_addr = 16'hFFFE;
      8: e_addr = 16'hFFFF;
      4, 5, 6: e_addr = {8'h01, m_sp};
      default: e_addr = 16'h0;
    endcase
    check(r, "ready", ready, m_ph == 3);
    check("R7", "re", re, e_re);
    check("R7", "we", we, e_we);
    if (e_re || e_we) check(r, "addr", addr, e_addr);
    check(r, "pc", pc, m_pc);
    check(r, "sp", sp, m_sp);
    check(r, "p", p, m_p);
    check("R1", "axy", {a, x, y}, {m_a, m_x, m_y});
    if (we) begin got_wr.push_back(wdata); got_wa.push_back(addr); end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic core_load(input logic [15:0] npc, input logic [7:0] nsp, input logic [7:0] np);
    core_we = 1'b1; pc_d = npc; sp_d = nsp; p_d = np;
    tick();
    core_we = 1'b0;
  endtask

  task automatic cmp_pushes(input string req);
    check(req, "push count", got_wr.size(), exp_wr.size());
    for (int i = 0; i < exp_wr.size() && i < got_wr.size(); i++) begin
      check(req, "push data", got_wr[i], exp_wr[i]);
      check(req, "push addr", got_wa[i], exp_wa[i]);
    end
    got_wr.delete(); exp_wr.delete(); got_wa.delete(); exp_wa.delete();
  endtask

  initial begin
    repeat (3) tick();
    // R1: reset state under rst_ni
    check("R1", "sp at reset", sp, 8'hFF);
    check("R1", "p at reset", p, 8'h34);
    check("R1", "ready at reset", ready, 1'b0);
    rst_ni = 1'b1;
    repeat (3) tick();
    // R2: vector fetch done
    check("R2", "ready after fetch", ready, 1'b1);
    check("R2", "pc from reset vector", pc, 16'h1234);

    // R4/R5/R6: basic interrupt entry
    core_load(16'h2000, 8'h80, 8'h00);
    irq = 1'b1;
    tick();
    irq = 1'b0;
    check("R4", "ready drops on accept", ready, 1'b0);
    // R8: write-back while not ready is ignored
    core_we = 1'b1; pc_d = 16'hDEAD; sp_d = 8'h11; p_d = 8'hFF;
    tick();
    core_we = 1'b0;
    repeat (4) tick();
    check("R6", "ready back", ready, 1'b1);
    check("R6", "pc from irq vector", pc, 16'h5678);
    check("R6", "I set", p[2], 1'b1);
    check("R5", "sp after pushes", sp, 8'h7D);
    cmp_pushes("R5");

    // R9: masked interrupt
    irq = 1'b1;
    repeat (5) tick();
    irq = 1'b0;
    check("R9", "ready held under mask", ready, 1'b1);
    check("R9", "no write under mask", got_wr.size(), 0);

    // R5: stack pointer wrap across 0x00
    core_load(16'hABCD, 8'h01, 8'hC1);
    irq = 1'b1;
    tick();
    irq = 1'b0;
    repeat (5) tick();
    check("R5", "sp after wrap", sp, 8'hFE);
    check("R5", "third push wraps to 0x01FF", got_wa.size() == 3 ? got_wa[2] : 16'h0, 16'h01FF);
    cmp_pushes("R5");

    // R3: reset held with interrupt pending
    core_load(16'h4000, 8'h50, 8'h00);
    rv_lo = 8'h00; rv_hi = 8'hC0;
    cpu_rst = 1'b1; irq = 1'b1;
    repeat (4) tick();
    check("R3", "ready low in reset", ready, 1'b0);
    check("R3", "no writes in reset", got_wr.size(), 0);
    check("R1", "p in reset", p, 8'h34);
    cpu_rst = 1'b0; irq = 1'b0;
    check("R1", "sp right after reset", sp, 8'hFF);
    repeat (3) tick();
    check("R2", "pc from new reset vector", pc, 16'hC000);

    // R10: reset in the middle of a push
    core_load(16'h3000, 8'h40, 8'h00);
    irq = 1'b1;
    tick();
    irq = 1'b0;
    tick();
    cpu_rst = 1'b1;
    tick();
    cpu_rst = 1'b0;
    check("R10", "writes before abort", got_wr.size(), 2);
    got_wr.delete(); got_wa.delete(); exp_wr.delete(); exp_wa.delete();
    repeat (4) tick();
    check("R10", "no writes after abort", got_wr.size(), 0);
    check("R10", "sp after abort", sp, 8'hFF);
    check("R10", "pc after abort", pc, 16'hC000);
    check("R10", "ready after abort", ready, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule